// File: doc/BRIEF.md
# Multicycle Load/Store Processor Core

This block is a compact 32-bit processor that runs each instruction as a short series of clock steps. It has one adder/logic unit and one memory port, and both are shared across those steps. The same unit increments the program counter, forms memory addresses and does the arithmetic. The same port supplies instruction words and also serves data loads and stores. Between steps, the intermediate values sit in internal holding registers: the instruction word, the two operands, the unit's result and the loaded data word.

A control state machine sequences the work through seven named states:

- `S_FETCH` reads the instruction and advances the program counter. It always moves to `S_DECODE`.
- `S_DECODE` reads both source registers and precomputes a branch target. It moves to `S_EXEC` for a recognised instruction and back to `S_FETCH` otherwise.
- `S_EXEC` branches on the instruction class:
  - a load goes to `S_MEMRD`;
  - a store goes to `S_MEMWR`;
  - a register-register operation goes to `S_RWB`;
  - a branch returns to `S_FETCH`.
- `S_MEMRD` moves to `S_LWB`.
- `S_MEMWR`, `S_RWB` and `S_LWB` each return to `S_FETCH`.

The memory port is assumed to return read data combinationally in the same cycle the address is presented. Writes are committed at the clock edge while the write enable is high.

Top module: `mc_core`

## Requirements
- R1: While synchronous reset is held and in the first cycle after it is released, the core is in the fetch step with program counter 0: `mem_addr` is 0 and `mem_we` is 0.
- R2: In every fetch cycle, `mem_addr` equals the program counter. The program counter then becomes that value plus 4, so straight-line code is fetched from consecutive word addresses.
- R3: Cycles per instruction depend on the opcode in bits [31:26]:
  - 6'h04 (branch-equal) takes 3 cycles;
  - 6'h2B (store word) takes 4 cycles;
  - 6'h00 (register-register) takes 4 cycles;
  - 6'h23 (load word) takes 5 cycles.
- R4: A load reads memory at address reg[bits 25:21] + sign-extended bits [15:0] in its fourth cycle. It writes the word read into register bits [20:16] at the end of its fifth cycle.
- R5: A store drives `mem_we` high for exactly its fourth cycle. In that cycle, `mem_addr` is reg[bits 25:21] + sign-extended bits [15:0] and `mem_wdata` is reg[bits 20:16].
- R6: A register-register instruction writes into register bits [15:11] the result of operands reg[25:21] and reg[20:16], selected by function bits [5:0]:
  - 6'h20 add;
  - 6'h22 subtract;
  - 6'h24 AND;
  - 6'h25 OR;
  - 6'h2A signed set-less-than, giving 1 or 0.
- R7: A branch-equal whose two registers are equal continues at (its address + 4) + (sign-extended bits [15:0] << 2). Otherwise it continues at its address + 4.
- R8: Register 0 always reads as zero, and writes to it are discarded.
- R9: An unrecognised opcode, or a register-register instruction with any function code other than those in R6, returns to fetch after the decode cycle (2 cycles total). It changes no register, no memory word and no program counter beyond the fetch increment.
- R10: `mem_we` is low in every cycle other than the fourth cycle of a store.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 32 | Byte address for instruction fetch or data access |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Read data, valid combinationally for `mem_addr` |
| mem_we | output | 1 | Write strobe for the current cycle |

## Verification
The embedded properties watch the control sequence on every cycle:

- fetch is always followed by decode, and every fetch adds 4 to the program counter;
- the program counter holds still outside the fetch and execute steps;
- a branch ends after its execute step, and load write-back is only reached from the memory-read step;
- the write strobe lasts one cycle and only follows an execute step;
- a zero source index yields a zero operand.

Whether results are correct can only be shown by the bench's scenarios, which compare every bus cycle against an instruction-level model. This covers arithmetic values, signed comparison, effective addresses, branch targets both taken and not taken, skipped instructions, and the lack of side effects from unrecognised encodings.

// File: rtl/mc_pkg.sv
package mc_pkg;
    localparam int XLEN   = 32;
    localparam int NREG   = 32;
    localparam int RIDX_W = $clog2(NREG);
    localparam int OPC_W  = 6;

    localparam logic [OPC_W-1:0] OP_RTYPE = 6'h00;
    localparam logic [OPC_W-1:0] OP_LW    = 6'h23;
    localparam logic [OPC_W-1:0] OP_SW    = 6'h2B;
    localparam logic [OPC_W-1:0] OP_BEQ   = 6'h04;

    localparam logic [OPC_W-1:0] FN_ADD = 6'h20;
    localparam logic [OPC_W-1:0] FN_SUB = 6'h22;
    localparam logic [OPC_W-1:0] FN_AND = 6'h24;
    localparam logic [OPC_W-1:0] FN_OR  = 6'h25;
    localparam logic [OPC_W-1:0] FN_SLT = 6'h2A;

    typedef enum logic [2:0] {
        S_FETCH, S_DECODE, S_EXEC, S_MEMRD, S_MEMWR, S_RWB, S_LWB
    } state_e;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT
    } alu_op_e;

    typedef enum logic [1:0] {
        SRCB_REG, SRCB_FOUR, SRCB_IMM, SRCB_BROFF
    } srcb_e;

    typedef struct packed {
        logic    ir_we;
        logic    pc_we;
        logic    pc_from_aluout;
        logic    srca_pc;
        srcb_e   srcb;
        alu_op_e op;
        logic    aluout_we;
        logic    ab_we;
        logic    mdr_we;
        logic    rf_we;
        logic    rf_dst_rd;
        logic    rf_from_mdr;
        logic    mem_we;
        logic    addr_from_aluout;
    } ctrl_t;
endpackage

// File: rtl/mc_alu.sv
module mc_alu
    import mc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y,
    output logic         zero
);
    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = a + b;
        endcase
    end

    assign zero = (y == '0);
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
    parameter int W  = 32,
    parameter int N  = 32,
    parameter int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ra_a,
    input  logic [AW-1:0] ra_b,
    input  logic [AW-1:0] wa,
    input  logic          we,
    input  logic [W-1:0]  wd,
    output logic [W-1:0]  rd_a,
    output logic [W-1:0]  rd_b
);
    logic [W-1:0] regs [N];

    generate
        for (genvar g = 0; g < N; g++) begin : g_ent
            if (g == 0) begin : g_zero
                assign regs[g] = '0;
            end else begin : g_flop
                always_ff @(posedge clk) begin
                    if (rst)
                        regs[g] <= '0;
                    else if (we && wa == AW'(g))
                        regs[g] <= wd;
                end
            end
        end
    endgenerate

    assign rd_a = regs[ra_a];
    assign rd_b = regs[ra_b];
endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
    import mc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [OPC_W-1:0] opcode,
    input  logic [OPC_W-1:0] funct,
    input  logic             alu_zero,
    output state_e           state,
    output ctrl_t            ctl
);
    state_e  nxt;
    logic    insn_ok;
    alu_op_e rop;

    // instruction recognition and function-code mapping
    always_comb begin
        rop     = ALU_ADD;
        insn_ok = 1'b0;
        case (opcode)
            OP_RTYPE: begin
                insn_ok = 1'b1;
                case (funct)
                    FN_ADD:  rop = ALU_ADD;
                    FN_SUB:  rop = ALU_SUB;
                    FN_AND:  rop = ALU_AND;
                    FN_OR:   rop = ALU_OR;
                    FN_SLT:  rop = ALU_SLT;
                    default: insn_ok = 1'b0;
                endcase
            end
            OP_LW, OP_SW, OP_BEQ: insn_ok = 1'b1;
            default:              insn_ok = 1'b0;
        endcase
    end

    // next-state logic
    always_comb begin
        nxt = S_FETCH;
        unique case (state)
            S_FETCH:  nxt = S_DECODE;
            S_DECODE: nxt = insn_ok ? S_EXEC : S_FETCH;
            S_EXEC: begin
                if (opcode == OP_LW)         nxt = S_MEMRD;
                else if (opcode == OP_SW)    nxt = S_MEMWR;
                else if (opcode == OP_RTYPE) nxt = S_RWB;
                else                         nxt = S_FETCH;
            end
            S_MEMRD:  nxt = S_LWB;
            S_MEMWR:  nxt = S_FETCH;
            S_RWB:    nxt = S_FETCH;
            S_LWB:    nxt = S_FETCH;
            default:  nxt = S_FETCH;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= S_FETCH;
        else     state <= nxt;
    end

    // per-state control outputs
    always_comb begin
        ctl      = '0;
        ctl.srcb = SRCB_REG;
        ctl.op   = ALU_ADD;
        unique case (state)
            S_FETCH: begin
                ctl.ir_we   = 1'b1;
                ctl.pc_we   = 1'b1;
                ctl.srca_pc = 1'b1;
                ctl.srcb    = SRCB_FOUR;
            end
            S_DECODE: begin
                ctl.ab_we     = 1'b1;
                ctl.aluout_we = 1'b1;
                ctl.srca_pc   = 1'b1;
                ctl.srcb      = SRCB_BROFF;
            end
            S_EXEC: begin
                if (opcode == OP_BEQ) begin
                    ctl.op             = ALU_SUB;
                    ctl.pc_from_aluout = 1'b1;
                    ctl.pc_we          = alu_zero;
                end else if (opcode == OP_LW || opcode == OP_SW) begin
                    ctl.srcb      = SRCB_IMM;
                    ctl.aluout_we = 1'b1;
                end else begin
                    ctl.op        = rop;
                    ctl.aluout_we = 1'b1;
                end
            end
            S_MEMRD: begin
                ctl.addr_from_aluout = 1'b1;
                ctl.mdr_we           = 1'b1;
            end
            S_MEMWR: begin
                ctl.addr_from_aluout = 1'b1;
                ctl.mem_we           = 1'b1;
            end
            S_RWB: begin
                ctl.rf_we     = 1'b1;
                ctl.rf_dst_rd = 1'b1;
            end
            S_LWB: begin
                ctl.rf_we       = 1'b1;
                ctl.rf_from_mdr = 1'b1;
            end
            default: ctl = '0;
        endcase
    end

    AST_FETCH_TO_DECODE: assert property (@(posedge clk) disable iff (rst)
        (state == S_FETCH) |=> (state == S_DECODE));  // R2
    AST_BRANCH_ENDS: assert property (@(posedge clk) disable iff (rst)
        (state == S_EXEC && opcode == OP_BEQ) |=> (state == S_FETCH));  // R3
    AST_LOAD_WB_ORDER: assert property (@(posedge clk) disable iff (rst)
        (state == S_LWB) |-> ($past(state) == S_MEMRD));  // R4
endmodule

// File: rtl/mc_core.sv
module mc_core
    import mc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    output logic [XLEN-1:0] mem_addr,
    output logic [XLEN-1:0] mem_wdata,
    input  logic [XLEN-1:0] mem_rdata,
    output logic            mem_we
);
    logic [XLEN-1:0] pc_q, ir_q, a_q, b_q, aluout_q, mdr_q;
    logic [XLEN-1:0] imm_se, srca, srcb, alu_y, rf_a, rf_b, rf_wd;
    logic [RIDX_W-1:0] rf_wa;
    logic   alu_zero;
    state_e state;
    ctrl_t  ctl;

    assign imm_se = {{(XLEN-16){ir_q[15]}}, ir_q[15:0]};

    mc_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .opcode   (ir_q[31:26]),
        .funct    (ir_q[5:0]),
        .alu_zero (alu_zero),
        .state    (state),
        .ctl      (ctl)
    );

    always_comb begin
        srca = ctl.srca_pc ? pc_q : a_q;
        unique case (ctl.srcb)
            SRCB_REG:   srcb = b_q;
            SRCB_FOUR:  srcb = XLEN'(4);
            SRCB_IMM:   srcb = imm_se;
            SRCB_BROFF: srcb = {imm_se[XLEN-3:0], 2'b00};
            default:    srcb = b_q;
        endcase
    end

    mc_alu #(.W(XLEN)) u_alu (
        .a    (srca),
        .b    (srcb),
        .op   (ctl.op),
        .y    (alu_y),
        .zero (alu_zero)
    );

    assign rf_wa = ctl.rf_dst_rd ? ir_q[15:11] : ir_q[20:16];
    assign rf_wd = ctl.rf_from_mdr ? mdr_q : aluout_q;

    mc_regfile #(.W(XLEN), .N(NREG), .AW(RIDX_W)) u_rf (
        .clk  (clk),
        .rst  (rst),
        .ra_a (ir_q[25:21]),
        .ra_b (ir_q[20:16]),
        .wa   (rf_wa),
        .we   (ctl.rf_we),
        .wd   (rf_wd),
        .rd_a (rf_a),
        .rd_b (rf_b)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q     <= '0;
            ir_q     <= '0;
            a_q      <= '0;
            b_q      <= '0;
            aluout_q <= '0;
            mdr_q    <= '0;
        end else begin
            if (ctl.pc_we)     pc_q     <= ctl.pc_from_aluout ? aluout_q : alu_y;
            if (ctl.ir_we)     ir_q     <= mem_rdata;
            if (ctl.ab_we)     a_q      <= rf_a;
            if (ctl.ab_we)     b_q      <= rf_b;
            if (ctl.aluout_we) aluout_q <= alu_y;
            if (ctl.mdr_we)    mdr_q    <= mem_rdata;
        end
    end

    assign mem_addr  = ctl.addr_from_aluout ? aluout_q : pc_q;
    assign mem_wdata = b_q;
    assign mem_we    = ctl.mem_we;

    AST_PC_PLUS_FOUR: assert property (@(posedge clk) disable iff (rst)
        (state == S_FETCH) |=> (pc_q == $past(pc_q) + XLEN'(4)));  // R2
    AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state inside {S_DECODE, S_MEMRD, S_MEMWR, S_RWB, S_LWB}) |=> $stable(pc_q));  // R9
    AST_WE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);  // R5
    AST_WE_AFTER_EXEC: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> ($past(state) == S_EXEC));  // R10
    AST_R0_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (state == S_DECODE && ir_q[25:21] == '0) |=> (a_q == '0));  // R8
endmodule

// File: tb/sim_mc_core.sv
`timescale 1ns/1ps
module sim_mc_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_we;
    int          n_run = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    logic [31:0] mem [256];
    assign mem_rdata = mem[mem_addr[9:2]];
    always @(posedge clk) if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;

    mc_core u0 (
        .clk       (clk),
        .rst       (rst),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_we    (mem_we)
    );

    // instruction-level reference model
    typedef struct {
        logic [31:0] addr;
        bit          chk_addr;
        logic        we;
        logic [31:0] wdata;
        string       tag;
    } exp_t;
    exp_t        q[$];
    logic [31:0] m_pc;
    logic [31:0] m_reg [32];
    logic [31:0] m_mem [256];

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction
    function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
        return {op, 5'(rs), 5'(rt), 16'(imm)};
    endfunction

    task automatic push(logic [31:0] a, bit ca, logic w, logic [31:0] d, string t);
        exp_t e;
        e.addr = a; e.chk_addr = ca; e.we = w; e.wdata = d; e.tag = t;
        q.push_back(e);
    endtask

    task automatic model_step();
        logic [31:0] ins, imm, ea, res, nxt;
        logic [5:0]  op, fn;
        int          rs, rt, rd;
        bit          ok;
        ins = m_mem[m_pc[9:2]];
        op  = ins[31:26]; fn = ins[5:0];
        rs  = int'(ins[25:21]); rt = int'(ins[20:16]); rd = int'(ins[15:11]);
        imm = {{16{ins[15]}}, ins[15:0]};
        nxt = m_pc + 32'd4;
        ok  = (op == 6'h23) || (op == 6'h2B) || (op == 6'h04) ||
              (op == 6'h00 && (fn == 6'h20 || fn == 6'h22 || fn == 6'h24 ||
                               fn == 6'h25 || fn == 6'h2A));
        push(m_pc, 1, 1'b0, '0, "R2");                 // fetch
        push('0, 0, 1'b0, '0, ok ? "R3" : "R9");       // decode
        if (ok) begin
            ea = m_reg[rs] + imm;
            case (op)
                6'h00: begin
                    case (fn)
                        6'h20: res = m_reg[rs] + m_reg[rt];
                        6'h22: res = m_reg[rs] - m_reg[rt];
                        6'h24: res = m_reg[rs] & m_reg[rt];
                        6'h25: res = m_reg[rs] | m_reg[rt];
                        default: res = ($signed(m_reg[rs]) < $signed(m_reg[rt])) ? 32'd1 : 32'd0;
                    endcase
                    push('0, 0, 1'b0, '0, "R10");
                    push('0, 0, 1'b0, '0, "R6");
                    if (rd != 0) m_reg[rd] = res;
                end
                6'h23: begin
                    push('0, 0, 1'b0, '0, "R10");
                    push(ea, 1, 1'b0, '0, "R4");
                    push('0, 0, 1'b0, '0, "R4");
                    if (rt != 0) m_reg[rt] = m_mem[ea[9:2]];
                end
                6'h2B: begin
                    push('0, 0, 1'b0, '0, "R10");
                    push(ea, 1, 1'b1, m_reg[rt], "R5");
                    m_mem[ea[9:2]] = m_reg[rt];
                end
                default: begin
                    push('0, 0, 1'b0, '0, "R7");
                    if (m_reg[rs] == m_reg[rt]) nxt = m_pc + 32'd4 + (imm << 2);
                end
            endcase
        end
        m_pc = nxt;
    endtask

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic chk_mem(int idx, logic [31:0] exp, string tag);
        check(mem[idx] === exp, tag, mem[idx], exp);
    endtask

    initial begin
        logic [31:0] prog [25];
        prog[0]  = enc_i(6'h23, 0, 1, 32'h100);  // lw r1
        prog[1]  = enc_i(6'h23, 0, 2, 32'h104);  // lw r2
        prog[2]  = enc_r(1, 2, 3, 6'h20);        // add
        prog[3]  = enc_r(1, 2, 4, 6'h22);        // sub
        prog[4]  = enc_r(1, 2, 5, 6'h24);        // and
        prog[5]  = enc_r(1, 2, 6, 6'h25);        // or
        prog[6]  = enc_r(2, 1, 7, 6'h2A);        // slt -3<7
        prog[7]  = enc_r(1, 2, 8, 6'h2A);        // slt 7<-3
        prog[8]  = enc_r(1, 1, 0, 6'h20);        // write r0
        prog[9]  = enc_i(6'h2B, 0, 0, 32'h180);
        prog[10] = enc_i(6'h04, 1, 2, 5);        // not taken
        prog[11] = enc_i(6'h04, 3, 3, 1);        // taken, skip next
        prog[12] = enc_i(6'h2B, 0, 1, 32'h184);
        prog[13] = 32'hFC00_0000;                // unknown opcode
        prog[14] = enc_r(1, 1, 9, 6'h3F);        // unknown funct
        prog[15] = enc_i(6'h2B, 0, 3, 32'h188);
        prog[16] = enc_i(6'h2B, 0, 4, 32'h18C);
        prog[17] = enc_i(6'h2B, 0, 5, 32'h190);
        prog[18] = enc_i(6'h2B, 0, 6, 32'h194);
        prog[19] = enc_i(6'h2B, 0, 7, 32'h198);
        prog[20] = enc_i(6'h2B, 0, 8, 32'h19C);
        prog[21] = enc_i(6'h2B, 0, 9, 32'h1A0);
        prog[22] = enc_i(6'h23, 0, 10, 32'h188);
        prog[23] = enc_i(6'h2B, 0, 10, 32'h1A4);
        prog[24] = enc_i(6'h04, 0, 0, -1);       // halt loop
        for (int i = 0; i < 256; i++) begin mem[i] = '0; m_mem[i] = '0; end
        for (int i = 0; i < 32; i++) m_reg[i] = '0;
        for (int i = 0; i < 25; i++) begin mem[i] = prog[i]; m_mem[i] = prog[i]; end
        mem[64] = 32'd7;         m_mem[64] = 32'd7;
        mem[65] = 32'hFFFF_FFFD; m_mem[65] = 32'hFFFF_FFFD;
        m_pc = '0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        check(mem_addr === 32'd0 && mem_we === 1'b0, "R1", mem_addr, 32'd0);
        @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(mem_addr === 32'd0 && mem_we === 1'b0, "R1", mem_addr, 32'd0);
        for (int c = 0; c < 320; c++) begin
            exp_t e;
            if (c != 0) @(negedge clk);
            if (q.size() == 0) model_step();
            e = q.pop_front();
            check(mem_we === e.we, {e.tag, " we"}, {31'd0, mem_we}, {31'd0, e.we});
            if (e.chk_addr)
                check(mem_addr === e.addr, {e.tag, " addr"}, mem_addr, e.addr);
            if (e.we)
                check(mem_wdata === e.wdata, {e.tag, " wdata"}, mem_wdata, e.wdata);
        end
        chk_mem(96,  32'd0,         "R8");   // r0 after write stays 0
        chk_mem(97,  32'd0,         "R7");   // skipped store
        chk_mem(98,  32'd4,         "R6");   // add
        chk_mem(99,  32'd10,        "R6");   // sub
        chk_mem(100, 32'd5,         "R6");   // and
        chk_mem(101, 32'hFFFF_FFFF, "R6");   // or
        chk_mem(102, 32'd1,         "R6");   // slt true
        chk_mem(103, 32'd0,         "R6");   // slt false
        chk_mem(104, 32'd0,         "R9");   // bad funct left r9
        chk_mem(105, 32'd4,         "R4");   // reload
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule